// File: doc/BRIEF.md
# Packed lane shuffle unit

This block rearranges the lanes of two 64-bit source vectors into one 64-bit result. The arrangement comes from a fixed set of shuffle patterns, and a small operation code selects the pattern. The code also selects how the sources are cut into lanes: eight byte lanes or four halfword lanes. One byte pattern interleaves source bytes with fill bytes that repeat each byte's sign bit. That pattern widens signed bytes to halfwords in a single pass.

The permutation network is pure wiring and multiplexers. Its result and the invalid-code flag are registered once, so the block has one cycle of latency. It accepts a new operation on every clock cycle. A code that names no pattern produces a zero result and raises the flag, and the surrounding pipeline can trap on that flag. Lane 0 is always the least significant lane. Operand `src_s` is the first source ("s") and `src_t` is the second ("t").

Top module: `shuf_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `result` becomes zero and `bad_code` becomes 0 on that edge, whatever the other inputs are.
- R2: Outputs change only at a rising clock edge. After each edge they reflect the inputs sampled at that edge, so latency is one cycle and a new code is accepted every cycle.
- R3: Format decode works as follows. When code bits [1:0] are 01, the halfword set is used with pattern index code[4:2]. When code bit 0 is 0, the byte set is used with pattern index code[4:1].
- R4: The byte mix patterns build their results as follows, listed from result lane 0 upward. Index 1 and index 6 give (t4,s4,t5,s5,t6,s6,t7,s7). Index 2 and index 7 give (t0,s0,t1,s1,t2,s2,t3,s3).
- R5: Byte index 3 gives (s0,f0,s1,f1,s2,f2,s3,f3). Each fill byte fk is 8'hFF when bit 7 of sk is 1 and 8'h00 otherwise.
- R6: Byte index 4 gives (t1,t3,t5,t7,s1,s3,s5,s7). Byte index 5 gives (t0,t2,t4,t6,s0,s2,s4,s6).
- R7: The halfword mix and pack patterns are as follows. Index 0 gives (t2,s2,t3,s3). Index 1 gives (t0,s0,t1,s1). Index 2 gives (t1,t3,s1,s3).
- R8: The other halfword patterns are as follows. Index 4 gives (t1,s0,t3,s2). Index 6 gives (t2,t3,s2,s3). Index 7 gives (t0,t1,s0,s1).
- R9: A code is invalid when any of the following holds: bits [1:0] are 11; it selects byte index 0; it selects a byte index of 8 or more; or it selects halfword index 3 or 5. An invalid code gives `bad_code` = 1 and `result` = 0 one cycle later.
- R10: Every code covered by R4 to R8 gives `bad_code` = 0 one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| src_s | input | 64 | First source vector (s lanes) |
| src_t | input | 64 | Second source vector (t lanes) |
| code | input | 5 | Shuffle operation code |
| result | output | 64 | Registered shuffled vector |
| bad_code | output | 1 | Registered flag for an invalid code |

## Verification
The bench builds the block with its default 64-bit data width and 5-bit code. At these widths the whole code space is 32 values, so every code is driven with several operand patterns. This includes the byte indices 8 to 15 that the top code bit opens up. Sign-fill is exercised with source bytes on both sides of 8'h80. Back-to-back random operations check that each registered result belongs to the code presented one edge earlier.

// File: rtl/shuf_pkg.sv
package shuf_pkg;
  typedef enum logic [1:0] {
    FMT_NONE = 2'd0,
    FMT_BYTE = 2'd1,
    FMT_HALF = 2'd2
  } fmt_e;

  localparam int BYTE_LANE_W = 8;
  localparam int HALF_LANE_W = 16;
  localparam int PAT_IDX_W   = 3;
endpackage

// File: rtl/shuf_decode.sv
module shuf_decode
  import shuf_pkg::*;
#(
  parameter int CODE_W = 5
) (
  input  logic [CODE_W-1:0]    code,
  output fmt_e                 fmt,
  output logic [PAT_IDX_W-1:0] idx,
  output logic                 bad
);
  localparam int BIDX_W = CODE_W - 1;
  localparam int HIDX_W = CODE_W - 2;

  logic [BIDX_W-1:0] bidx;
  logic [HIDX_W-1:0] hidx;

  assign bidx = code[CODE_W-1:1];
  assign hidx = code[CODE_W-1:2];

  always_comb begin
    fmt = FMT_NONE;
    idx = '0;
    bad = 1'b1;
    if (!code[0]) begin
      fmt = FMT_BYTE;
      idx = bidx[PAT_IDX_W-1:0];
      bad = (bidx[PAT_IDX_W-1:0] == '0) || (|(bidx >> PAT_IDX_W));
    end else if (!code[1]) begin
      fmt = FMT_HALF;
      idx = hidx[PAT_IDX_W-1:0];
      bad = (hidx[PAT_IDX_W-1:0] == 3'd3) || (hidx[PAT_IDX_W-1:0] == 3'd5)
            || (|(hidx >> PAT_IDX_W));
    end
  end
endmodule

// File: rtl/shuf_lane_net.sv
module shuf_lane_net
  import shuf_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int LANE_W   = 8,
  parameter bit HALF_SET = 1'b0
) (
  input  logic [DATA_W-1:0]    src_s,
  input  logic [DATA_W-1:0]    src_t,
  input  logic [PAT_IDX_W-1:0] idx,
  output logic [DATA_W-1:0]    dout
);
  localparam int N = DATA_W / LANE_W;
  localparam int H = N / 2;

  logic [LANE_W-1:0] sl [N];
  logic [LANE_W-1:0] tl [N];

  for (genvar k = 0; k < N; k++) begin : g_split
    assign sl[k] = src_s[k*LANE_W +: LANE_W];
    assign tl[k] = src_t[k*LANE_W +: LANE_W];
  end

  for (genvar gl = 0; gl < N; gl++) begin : g_lane
    localparam int J    = gl / 2;
    localparam bit ODD  = (gl % 2) == 1;
    localparam bit LOWH = gl < H;
    localparam int PH   = LOWH ? 2*gl + 1 : 2*(gl - H) + 1;
    localparam int PL   = LOWH ? 2*gl     : 2*(gl - H);

    logic [LANE_W-1:0] mixh, mixl, packh, lane;

    assign mixh  = ODD ? sl[H + J] : tl[H + J];
    assign mixl  = ODD ? sl[J] : tl[J];
    assign packh = LOWH ? tl[PH] : sl[PH];

    if (HALF_SET) begin : g_half
      localparam int BF = ODD ? gl - 1 : gl + 1;
      localparam int RA = LOWH ? H + gl : gl;
      localparam int RB = LOWH ? gl : gl - H;
      logic [LANE_W-1:0] bfly, repa, repb;
      assign bfly = ODD ? sl[BF] : tl[BF];
      assign repa = LOWH ? tl[RA] : sl[RA];
      assign repb = LOWH ? tl[RB] : sl[RB];
      always_comb begin
        case (idx)
          3'd0:    lane = mixh;
          3'd1:    lane = mixl;
          3'd2:    lane = packh;
          3'd4:    lane = bfly;
          3'd6:    lane = repa;
          3'd7:    lane = repb;
          default: lane = '0;
        endcase
      end
    end else begin : g_byte
      logic [LANE_W-1:0] packl, fill;
      assign packl = LOWH ? tl[PL] : sl[PL];
      assign fill  = ODD ? {LANE_W{sl[J][LANE_W-1]}} : sl[J];
      always_comb begin
        case (idx)
          3'd1, 3'd6: lane = mixh;
          3'd2, 3'd7: lane = mixl;
          3'd3:       lane = fill;
          3'd4:       lane = packh;
          3'd5:       lane = packl;
          default:    lane = '0;
        endcase
      end
    end

    assign dout[gl*LANE_W +: LANE_W] = lane;
  end
endmodule

// File: rtl/shuf_unit.sv
module shuf_unit
  import shuf_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] src_s,
  input  logic [DATA_W-1:0] src_t,
  input  logic [CODE_W-1:0] code,
  output logic [DATA_W-1:0] result,
  output logic              bad_code
);
  fmt_e                 fmt;
  logic [PAT_IDX_W-1:0] idx;
  logic                 bad;
  logic [DATA_W-1:0]    byte_res, half_res, next_res;

  shuf_decode #(.CODE_W(CODE_W)) dec_i (
    .code (code),
    .fmt  (fmt),
    .idx  (idx),
    .bad  (bad)
  );

  shuf_lane_net #(.DATA_W(DATA_W), .LANE_W(BYTE_LANE_W), .HALF_SET(1'b0)) byte_net_i (
    .src_s (src_s),
    .src_t (src_t),
    .idx   (idx),
    .dout  (byte_res)
  );

  shuf_lane_net #(.DATA_W(DATA_W), .LANE_W(HALF_LANE_W), .HALF_SET(1'b1)) half_net_i (
    .src_s (src_s),
    .src_t (src_t),
    .idx   (idx),
    .dout  (half_res)
  );

  always_comb begin
    next_res = '0;
    if (!bad) begin
      case (fmt)
        FMT_BYTE: next_res = byte_res;
        FMT_HALF: next_res = half_res;
        default:  next_res = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result   <= '0;
      bad_code <= 1'b0;
    end else begin
      result   <= next_res;
      bad_code <= bad;
    end
  end
endmodule

// File: rtl/shuf_unit_chk.sv
module shuf_unit_chk #(
  parameter int DATA_W = 64,
  parameter int CODE_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] src_s,
  input logic [DATA_W-1:0] src_t,
  input logic [CODE_W-1:0] code,
  input logic [DATA_W-1:0] result,
  input logic              bad_code
);
  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (result == '0 && !bad_code));

  p_bad_zero_result_r9: assert property (@(posedge clk) disable iff (rst)
    bad_code |-> result == '0);

  p_low_bits_11_bad_r9: assert property (@(posedge clk) disable iff (rst)
    (code[1:0] == 2'b11) |=> bad_code);

  p_byte_mix_valid_r10: assert property (@(posedge clk) disable iff (rst)
    (code == CODE_W'(5'b00010)) |=> !bad_code);

  p_sign_fill_r5: assert property (@(posedge clk) disable iff (rst)
    (code == CODE_W'(5'b00110)) |=> result[15:8] == {8{$past(src_s[7])}});

  p_half_repb_r8: assert property (@(posedge clk) disable iff (rst)
    (code == CODE_W'(5'b11101)) |=> result[31:16] == $past(src_t[31:16]));

  p_stable_in_out_r2: assert property (@(posedge clk) disable iff (rst)
    ($stable(src_s) && $stable(src_t) && $stable(code) && !$past(rst)) |=> $stable(result));
endmodule

bind shuf_unit shuf_unit_chk #(.DATA_W(DATA_W), .CODE_W(CODE_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .src_s    (src_s),
  .src_t    (src_t),
  .code     (code),
  .result   (result),
  .bad_code (bad_code)
);

// File: tb/shuf_unit_tb_top.sv
module shuf_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] src_s = '0;
  logic [63:0] src_t = '0;
  logic [4:0]  code = '0;
  logic [63:0] result;
  logic        bad_code;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  typedef struct {
    logic [63:0] exp_data;
    logic        exp_bad;
    logic [4:0]  code;
    string       tag;
  } item_t;

  item_t sb_q[$];

  always #10 clk = ~clk;

  shuf_unit dut_i (
    .clk      (clk),
    .rst      (rst),
    .src_s    (src_s),
    .src_t    (src_t),
    .code     (code),
    .result   (result),
    .bad_code (bad_code)
  );

  function automatic logic [7:0] bl(input logic [63:0] v, input int k);
    return v[8*k +: 8];
  endfunction

  function automatic logic [15:0] hl(input logic [63:0] v, input int k);
    return v[16*k +: 16];
  endfunction

  function automatic logic [7:0] sf(input logic [63:0] v, input int k);
    return v[8*k+7] ? 8'hFF : 8'h00;
  endfunction

  function automatic item_t model(input logic [63:0] s, input logic [63:0] t, input logic [4:0] c);
    item_t it;
    it.code = c;
    it.exp_data = '0;
    it.exp_bad = 1'b1;
    it.tag = "R3/R9";
    if (c[0] == 1'b0) begin
      it.exp_bad = 1'b0;
      case (c[4:1])
        4'd1, 4'd6: begin
          it.exp_data = {bl(s,7),bl(t,7),bl(s,6),bl(t,6),bl(s,5),bl(t,5),bl(s,4),bl(t,4)};
          it.tag = "R3/R4";
        end
        4'd2, 4'd7: begin
          it.exp_data = {bl(s,3),bl(t,3),bl(s,2),bl(t,2),bl(s,1),bl(t,1),bl(s,0),bl(t,0)};
          it.tag = "R3/R4";
        end
        4'd3: begin
          it.exp_data = {sf(s,3),bl(s,3),sf(s,2),bl(s,2),sf(s,1),bl(s,1),sf(s,0),bl(s,0)};
          it.tag = "R3/R5";
        end
        4'd4: begin
          it.exp_data = {bl(s,7),bl(s,5),bl(s,3),bl(s,1),bl(t,7),bl(t,5),bl(t,3),bl(t,1)};
          it.tag = "R3/R6";
        end
        4'd5: begin
          it.exp_data = {bl(s,6),bl(s,4),bl(s,2),bl(s,0),bl(t,6),bl(t,4),bl(t,2),bl(t,0)};
          it.tag = "R3/R6";
        end
        default: it.exp_bad = 1'b1;
      endcase
    end else if (c[1] == 1'b0) begin
      it.exp_bad = 1'b0;
      case (c[4:2])
        3'd0: begin it.exp_data = {hl(s,3),hl(t,3),hl(s,2),hl(t,2)}; it.tag = "R3/R7"; end
        3'd1: begin it.exp_data = {hl(s,1),hl(t,1),hl(s,0),hl(t,0)}; it.tag = "R3/R7"; end
        3'd2: begin it.exp_data = {hl(s,3),hl(s,1),hl(t,3),hl(t,1)}; it.tag = "R3/R7"; end
        3'd4: begin it.exp_data = {hl(s,2),hl(t,3),hl(s,0),hl(t,1)}; it.tag = "R3/R8"; end
        3'd6: begin it.exp_data = {hl(s,3),hl(s,2),hl(t,3),hl(t,2)}; it.tag = "R3/R8"; end
        3'd7: begin it.exp_data = {hl(s,1),hl(s,0),hl(t,1),hl(t,0)}; it.tag = "R3/R8"; end
        default: it.exp_bad = 1'b1;
      endcase
    end
    return it;
  endfunction

  task automatic drive(input logic [63:0] s, input logic [63:0] t, input logic [4:0] c);
    @(negedge clk);
    src_s = s;
    src_t = t;
    code  = c;
    sb_q.push_back(model(s, t, c));
  endtask

  // Monitor: each registered result is compared one edge after its inputs (R2).
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        n_checks++;
        if (result !== it.exp_data) begin
          n_fails++;
          $display("FAIL R2/%s code=%b result=%h expected=%h", it.tag, it.code, result, it.exp_data);
        end
        n_checks++;
        if (bad_code !== it.exp_bad) begin
          n_fails++;
          $display("FAIL %s code=%b bad_code=%b expected=%b",
                   it.exp_bad ? "R9" : "R10", it.code, bad_code, it.exp_bad);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog expired before end of stimulus");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    // R1: reset dominates a valid code with nonzero data
    @(negedge clk);
    src_s = 64'hFEDC_BA98_7654_3210;
    src_t = 64'h0123_4567_89AB_CDEF;
    code  = 5'b00010;
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_checks++;
    if (result !== 64'h0 || bad_code !== 1'b0) begin
      n_fails++;
      $display("FAIL R1 result=%h bad_code=%b expected=0 and 0", result, bad_code);
    end
    rst = 1'b0;

    // Exhaustive code sweep, with sign bits set and clear in the s bytes (R5)
    for (int c = 0; c < 32; c++) begin
      drive(64'h8877_6655_4433_2211, 64'hF0E1_D2C3_B4A5_9687, 5'(c));
      drive(64'h7F80_00FF_017E_81C0, 64'h1122_3344_5566_7788, 5'(c));
      drive(64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 5'(c));
    end

    // Back-to-back random operations (R2)
    for (int n = 0; n < 300; n++) begin
      drive({$urandom, $urandom}, {$urandom, $urandom}, 5'($urandom));
    end

    @(negedge clk);
    while (sb_q.size() > 0) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule